// File: doc/BRIEF.md
# Debug Instruction Injection Controller

This block is the register-facing front end of a debug port for a core with four hardware threads. An external debugger uses a 64-bit register port, with a small register number, to halt chosen threads and to push one 32-bit instruction into a chosen thread. It then polls a status field until the core reports that the instruction finished, faulted or trapped. Toward the core the block emits a one-cycle injection strobe. The strobe carries the instruction, the thread index and a four-bit operand extension mask. A separate one-cycle pipeline flush request is also available. In return the block takes single-cycle completion, error and interrupt indications, together with a 64-bit result.

Injection is guarded three ways. The configuration register must have both its debug enable and its injection enable set. The command must carry both its enable and execute flags. The selected thread must already be halted by its stop bit. A request that fails any of these is not forwarded, and it latches an error status so that polling software sees a completion rather than spinning. The instruction and the command can be written together in one 64-bit access, or the instruction can be loaded on its own first.

Top module: `dbg_inject_ctl`

## Requirements
- R1: After reset every register reads as zero, and inj_valid, flush_req and thr_ctl are zero.
- R2: Reads return the instruction at 0x29, {cmd[31:3], status[2:0]} at 0x2a, the 64-bit data register at 0x2d, thread control at 0x30 and configuration at 0x33. The upper 32 bits are zero except at 0x2d. Every other address, including 0x28, 0x31 and 0x32, reads zero.
- R3: A write to 0x28 loads the instruction from bits 63:32 and the command from bits 31:0 in one access. A write to 0x29 loads only the instruction, and a later write to 0x2a uses that stored instruction.
- R4: A command write with enable (bit 19) and execute (bit 16) set is granted when configuration bits 31 and 30 are both set and the stop bit 31-n of the selected thread n (command bits 18:17) is set. A granted command raises inj_valid for exactly the cycle after the write, with inj_insn, inj_thread and inj_ext (command bits 31:28). It also clears all three status bits.
- R5: A command write with enable and execute set that is not granted raises no inj_valid and sets status to error only (binary 010).
- R6: While an injection is outstanding, core_done, core_error and core_intr set status bits 0, 1 and 2 respectively. The same pulse latches core_result into the data register and ends the outstanding injection. Pulses arriving when nothing is outstanding change neither status nor data. A granted or refused execute in the same cycle takes precedence over a core pulse.
- R7: A command write with enable and flush (bit 11) set raises flush_req for one cycle with inj_thread set to the selected thread. With execute clear, no inj_valid is raised and status is unchanged.
- R8: A command write with enable clear, including writing zero, issues nothing and leaves status unchanged.
- R9: Writing 0x30 loads thread control and writing 0x31 ANDs the written value into it. Writing 0x32 ORs the written value into it. Only bits 31:16 (stop, step, run, power-managed per thread) and bit 11 (asynchronous interrupt disable) are kept; all other bits read zero.
- R10: The thr_ctl output always equals the thread control register.
- R11: A write to 0x2d loads the data register with the full 64-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register number for reads and writes |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr, combinational |
| inj_valid | output | 1 | One-cycle instruction injection strobe |
| inj_insn | output | 32 | Instruction to inject |
| inj_thread | output | 2 | Target thread for injection or flush |
| inj_ext | output | 4 | Operand extension mask |
| flush_req | output | 1 | One-cycle pipeline flush request |
| core_done | input | 1 | Core reports injected instruction completed |
| core_error | input | 1 | Core reports injected instruction faulted |
| core_intr | input | 1 | Core reports injected instruction took an interrupt |
| core_result | input | 64 | Result captured with a core indication |
| thr_ctl | output | 32 | Current thread control register |

## Verification
On every cycle the assertions check four things. Any injection strobe coincides with both configuration enables and the target thread's stop bit. Status is clear and an injection outstanding whenever the strobe is up. The thread control register never holds an undefined bit. The alias writes never set a bit under AND or drop one under OR. Refusals, ignored commands and accepted completions are also checked for their next-cycle status effect. The bench's scenarios are needed for the rest: the end-to-end sequences of halting a thread, injecting through either the combined or the split write path, completing, and then reading status and data back. They also cover that stray core pulses leave the data register untouched and that a flush-only command never injects.

// File: rtl/dbg_inject_pkg.sv
package dbg_inject_pkg;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 64;
    localparam int REG_W  = 32;
    localparam int NTHR   = 4;
    localparam int TID_W  = $clog2(NTHR);
    localparam int EXT_W  = 4;
    localparam int STAT_W = 3;

    // register numbers
    localparam logic [ADDR_W-1:0] A_INSCMD  = 6'h28;
    localparam logic [ADDR_W-1:0] A_INS     = 6'h29;
    localparam logic [ADDR_W-1:0] A_CMD     = 6'h2a;
    localparam logic [ADDR_W-1:0] A_DATA    = 6'h2d;
    localparam logic [ADDR_W-1:0] A_THR     = 6'h30;
    localparam logic [ADDR_W-1:0] A_THR_AND = 6'h31;
    localparam logic [ADDR_W-1:0] A_THR_OR  = 6'h32;
    localparam logic [ADDR_W-1:0] A_CFG     = 6'h33;

    // command field positions
    localparam int C_EXT_LO = 28;
    localparam int C_EN     = 19;
    localparam int C_TID_LO = 17;
    localparam int C_EXEC   = 16;
    localparam int C_FLUSH  = 11;

    localparam int CFG_DBG = 31;
    localparam int CFG_INJ = 30;

    localparam logic [REG_W-1:0]  THR_MASK = 32'hFFFF_0800;
    localparam logic [STAT_W-1:0] ST_ERR   = 3'b010;

    typedef struct packed {
        logic [REG_W-1:0] thr;
        logic [REG_W-1:0] cfg;
    } ctl_state_t;

    typedef struct packed {
        logic [REG_W-1:0]  insn;
        logic [REG_W-1:0]  cmd;
        logic [STAT_W-1:0] stat;
        logic [DATA_W-1:0] data;
        logic              busy;
        logic              inj_valid;
        logic [REG_W-1:0]  inj_insn;
        logic [TID_W-1:0]  inj_tid;
        logic [EXT_W-1:0]  inj_ext;
        logic              flush;
    } ram_state_t;
endpackage

// File: rtl/dbg_ctl_regs.sv
module dbg_ctl_regs
    import dbg_inject_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  thr_q,
    output logic [REG_W-1:0]  cfg_q
);
    ctl_state_t q, d;

    always_comb begin
        d = q;
        if (wr_en) begin
            case (addr)
                A_THR:     d.thr = wdata & THR_MASK;
                A_THR_AND: d.thr = q.thr & wdata;
                A_THR_OR:  d.thr = (q.thr | wdata) & THR_MASK;
                A_CFG:     d.cfg = wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign thr_q = q.thr;
    assign cfg_q = q.cfg;

    p_thr_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.thr & ~THR_MASK) == '0);

    p_and_no_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_THR_AND) |=> ((q.thr & ~$past(q.thr)) == '0));

    p_or_no_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_THR_OR) |=> ((q.thr & $past(q.thr)) == $past(q.thr)));
endmodule

// File: rtl/dbg_ram_unit.sv
module dbg_ram_unit
    import dbg_inject_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cfg_dbg,
    input  logic              cfg_inj,
    input  logic [NTHR-1:0]   thr_stop,
    input  logic              core_done,
    input  logic              core_error,
    input  logic              core_intr,
    input  logic [DATA_W-1:0] core_result,
    output logic [REG_W-1:0]  insn_rd,
    output logic [REG_W-1:0]  cmd_rd,
    output logic [DATA_W-1:0] data_rd,
    output logic              inj_valid,
    output logic [REG_W-1:0]  inj_insn,
    output logic [TID_W-1:0]  inj_thread,
    output logic [EXT_W-1:0]  inj_ext,
    output logic              flush_req
);
    ram_state_t q, d;

    logic             cmd_wr, exec_req, grant, any_pulse;
    logic [REG_W-1:0] new_cmd, new_insn;
    logic [TID_W-1:0] tid;

    always_comb begin
        cmd_wr    = wr_en && (addr == A_INSCMD || addr == A_CMD);
        new_cmd   = {wdata[REG_W-1:STAT_W], {STAT_W{1'b0}}};
        new_insn  = (addr == A_INSCMD) ? wdata[DATA_W-1:REG_W] : q.insn;
        tid       = new_cmd[C_TID_LO +: TID_W];
        exec_req  = cmd_wr && new_cmd[C_EN] && new_cmd[C_EXEC];
        grant     = exec_req && cfg_dbg && cfg_inj && thr_stop[tid];
        any_pulse = core_done || core_error || core_intr;

        d           = q;
        d.inj_valid = 1'b0;
        d.flush     = 1'b0;

        if (wr_en && addr == A_INS)  d.insn = wdata[REG_W-1:0];
        if (wr_en && addr == A_DATA) d.data = wdata;

        if (cmd_wr) begin
            d.insn = new_insn;
            d.cmd  = new_cmd;
            if (new_cmd[C_EN] && new_cmd[C_FLUSH]) begin
                d.flush   = 1'b1;
                d.inj_tid = tid;
            end
        end

        if (exec_req) begin
            if (grant) begin
                d.inj_valid = 1'b1;
                d.inj_insn  = new_insn;
                d.inj_tid   = tid;
                d.inj_ext   = new_cmd[C_EXT_LO +: EXT_W];
                d.stat      = '0;
                d.busy      = 1'b1;
            end else begin
                d.stat = ST_ERR;
                d.busy = 1'b0;
            end
        end else if (q.busy && any_pulse) begin
            d.stat = q.stat | {core_intr, core_error, core_done};
            d.data = core_result;
            d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign insn_rd    = q.insn;
    assign cmd_rd     = {q.cmd[REG_W-1:STAT_W], q.stat};
    assign data_rd    = q.data;
    assign inj_valid  = q.inj_valid;
    assign inj_insn   = q.inj_insn;
    assign inj_thread = q.inj_tid;
    assign inj_ext    = q.inj_ext;
    assign flush_req  = q.flush;

    p_issue_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q.inj_valid |-> (q.stat == '0 && q.busy));

    p_refuse_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_req && !grant) |=> (q.stat == ST_ERR && !q.inj_valid));

    p_done_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && core_done && !exec_req) |=> (q.stat[0] && !q.busy));

    p_idle_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !new_cmd[C_EN]) |=> (!q.inj_valid && !q.flush && $stable(q.stat)));
endmodule

// File: rtl/dbg_inject_ctl.sv
module dbg_inject_ctl
    import dbg_inject_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              inj_valid,
    output logic [REG_W-1:0]  inj_insn,
    output logic [TID_W-1:0]  inj_thread,
    output logic [EXT_W-1:0]  inj_ext,
    output logic              flush_req,
    input  logic              core_done,
    input  logic              core_error,
    input  logic              core_intr,
    input  logic [DATA_W-1:0] core_result,
    output logic [REG_W-1:0]  thr_ctl
);
    localparam int PAD_W = DATA_W - REG_W;

    logic [REG_W-1:0]  thr_q, cfg_q, insn_rd, cmd_rd;
    logic [DATA_W-1:0] data_rd;
    logic [NTHR-1:0]   thr_stop;

    dbg_ctl_regs u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata[REG_W-1:0]),
        .thr_q (thr_q),
        .cfg_q (cfg_q)
    );

    // stop bit of thread n sits at REG_W-1-n
    for (genvar n = 0; n < NTHR; n++) begin : g_stop
        assign thr_stop[n] = thr_q[REG_W-1-n];
    end

    dbg_ram_unit u_ram (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .cfg_dbg     (cfg_q[CFG_DBG]),
        .cfg_inj     (cfg_q[CFG_INJ]),
        .thr_stop    (thr_stop),
        .core_done   (core_done),
        .core_error  (core_error),
        .core_intr   (core_intr),
        .core_result (core_result),
        .insn_rd     (insn_rd),
        .cmd_rd      (cmd_rd),
        .data_rd     (data_rd),
        .inj_valid   (inj_valid),
        .inj_insn    (inj_insn),
        .inj_thread  (inj_thread),
        .inj_ext     (inj_ext),
        .flush_req   (flush_req)
    );

    always_comb begin
        case (reg_addr)
            A_INS:   reg_rdata = {{PAD_W{1'b0}}, insn_rd};
            A_CMD:   reg_rdata = {{PAD_W{1'b0}}, cmd_rd};
            A_DATA:  reg_rdata = data_rd;
            A_THR:   reg_rdata = {{PAD_W{1'b0}}, thr_q};
            A_CFG:   reg_rdata = {{PAD_W{1'b0}}, cfg_q};
            default: reg_rdata = '0;
        endcase
    end

    assign thr_ctl = thr_q;

    p_inject_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        inj_valid |-> (cfg_q[CFG_DBG] && cfg_q[CFG_INJ] && thr_stop[inj_thread]));
endmodule

// File: tb/dbg_inject_ctl_test.sv
module dbg_inject_ctl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        inj_valid, flush_req;
    logic [31:0] inj_insn, thr_ctl;
    logic [1:0]  inj_thread;
    logic [3:0]  inj_ext;
    logic        core_done = 1'b0, core_error = 1'b0, core_intr = 1'b0;
    logic [63:0] core_result = '0;

    int nchk = 0;
    int nfail = 0;
    bit fin = 1'b0;

    always #5 clk = ~clk;

    dbg_inject_ctl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .inj_valid(inj_valid),
        .inj_insn(inj_insn), .inj_thread(inj_thread), .inj_ext(inj_ext),
        .flush_req(flush_req), .core_done(core_done), .core_error(core_error),
        .core_intr(core_intr), .core_result(core_result), .thr_ctl(thr_ctl)
    );

    // behavioural reference model
    logic [31:0] m_insn, m_cmd, m_thr, m_cfg, m_iinsn;
    logic [2:0]  m_stat;
    logic [63:0] m_data;
    logic        m_busy, m_iv, m_fl;
    logic [1:0]  m_tid;
    logic [3:0]  m_ext;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_insn = 0; m_cmd = 0; m_thr = 0; m_cfg = 0; m_iinsn = 0;
            m_stat = 0; m_data = 0; m_busy = 0; m_iv = 0; m_fl = 0;
            m_tid = 0; m_ext = 0;
        end else begin
            bit took;
            logic [31:0] c;
            int t;
            took = 0;
            m_iv = 0;
            m_fl = 0;
            if (reg_wr) begin
                if (reg_addr == 6'h29) m_insn = reg_wdata[31:0];
                if (reg_addr == 6'h2d) m_data = reg_wdata;
                if (reg_addr == 6'h30) m_thr = reg_wdata[31:0] & 32'hFFFF0800;
                if (reg_addr == 6'h31) m_thr = m_thr & reg_wdata[31:0];
                if (reg_addr == 6'h32) m_thr = (m_thr | reg_wdata[31:0]) & 32'hFFFF0800;
                if (reg_addr == 6'h33) m_cfg = reg_wdata[31:0];
                if (reg_addr == 6'h28 || reg_addr == 6'h2a) begin
                    c = reg_wdata[31:0] & 32'hFFFFFFF8;
                    if (reg_addr == 6'h28) m_insn = reg_wdata[63:32];
                    m_cmd = c;
                    t = int'(c[18:17]);
                    if (c[19] && c[11]) begin m_fl = 1; m_tid = c[18:17]; end
                    if (c[19] && c[16]) begin
                        took = 1;
                        if (m_cfg[31] && m_cfg[30] && m_thr[31-t]) begin
                            m_iv = 1; m_iinsn = m_insn; m_tid = c[18:17];
                            m_ext = c[31:28]; m_stat = 0; m_busy = 1;
                        end else begin
                            m_stat = 3'b010; m_busy = 0;
                        end
                    end
                end
            end
            if (!took && m_busy && (core_done || core_error || core_intr)) begin
                if (core_done)  m_stat[0] = 1;
                if (core_error) m_stat[1] = 1;
                if (core_intr)  m_stat[2] = 1;
                m_data = core_result;
                m_busy = 0;
            end
        end
    end

    function automatic logic [63:0] m_read(input logic [5:0] a);
        case (a)
            6'h29: return {32'h0, m_insn};
            6'h2a: return {32'h0, m_cmd[31:3], m_stat};
            6'h2d: return m_data;
            6'h30: return {32'h0, m_thr};
            6'h33: return {32'h0, m_cfg};
            default: return 64'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare against the model on every clock, away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            check("R4 inj_valid", {63'h0, inj_valid}, {63'h0, m_iv});
            if (m_iv) begin
                check("R4 inj_insn", {32'h0, inj_insn}, {32'h0, m_iinsn});
                check("R4 inj_ext", {60'h0, inj_ext}, {60'h0, m_ext});
            end
            check("R7 flush_req", {63'h0, flush_req}, {63'h0, m_fl});
            check("R7 inj_thread", {62'h0, inj_thread}, {62'h0, m_tid});
            check("R10 thr_ctl", {32'h0, thr_ctl}, {32'h0, m_thr});
            check("R2 reg_rdata", reg_rdata, m_read(reg_addr));
        end
    end

    task automatic wr(input logic [5:0] a, input logic [63:0] v);
        @(negedge clk); #2;
        reg_wr = 1; reg_addr = a; reg_wdata = v;
        @(negedge clk); #2;
        reg_wr = 0;
    endtask

    task automatic pulse(input logic dn, input logic er, input logic it, input logic [63:0] r);
        @(negedge clk); #2;
        core_done = dn; core_error = er; core_intr = it; core_result = r;
        @(negedge clk); #2;
        core_done = 0; core_error = 0; core_intr = 0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [63:0] exp, input string tag);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    initial begin
        #(200000 * 10);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        fin = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #2 rst_n = 1;
        // R1 reset state
        rd(6'h29, 64'h0, "R1 insn after reset");
        rd(6'h2a, 64'h0, "R1 cmd after reset");
        rd(6'h2d, 64'h0, "R1 data after reset");
        rd(6'h30, 64'h0, "R1 thr after reset");
        rd(6'h33, 64'h0, "R1 cfg after reset");
        check("R1 outputs after reset", {inj_valid, flush_req, thr_ctl}, 34'h0);

        // R5 execute refused while configuration disabled
        wr(6'h2a, 64'h000B0000);
        check("R5 no inject when cfg off", {63'h0, inj_valid}, 64'h0);
        rd(6'h2a, 64'h000B0002, "R5 error status");

        // R9 thread control and aliases
        wr(6'h33, 64'hC0000000);
        wr(6'h30, 64'hFFFFFFFF_FFFFFFFF);
        rd(6'h30, 64'hFFFF0800, "R9 masked write");
        wr(6'h31, 64'hBFFFFFFF);
        rd(6'h30, 64'hBFFF0800, "R9 AND alias");
        check("R10 thr_ctl", {32'h0, thr_ctl}, 64'hBFFF0800);
        wr(6'h2a, 64'h000B0000);
        check("R5 no inject thread running", {63'h0, inj_valid}, 64'h0);
        rd(6'h2a, 64'h000B0002, "R5 error stop clear");
        wr(6'h32, 64'h40000000);
        rd(6'h30, 64'hFFFF0800, "R9 OR alias");

        // R3 R4 combined write injects
        wr(6'h28, 64'h7C0004AC_F00B0000);
        check("R4 inj_valid", {63'h0, inj_valid}, 64'h1);
        check("R3 inj_insn from 0x28", {32'h0, inj_insn}, 64'h7C0004AC);
        check("R4 inj_thread", {62'h0, inj_thread}, 64'h1);
        check("R4 inj_ext", {60'h0, inj_ext}, 64'hF);
        rd(6'h2a, 64'hF00B0000, "R4 status cleared");
        rd(6'h29, 64'h7C0004AC, "R3 insn stored");
        rd(6'h28, 64'h0, "R2 0x28 reads zero");

        // R6 completion
        pulse(1, 0, 0, 64'h12345678_9ABCDEF0);
        rd(6'h2a, 64'hF00B0001, "R6 done status");
        rd(6'h2d, 64'h12345678_9ABCDEF0, "R6 result latched");
        pulse(0, 1, 0, 64'h55);
        rd(6'h2a, 64'hF00B0001, "R6 stray pulse ignored");
        rd(6'h2d, 64'h12345678_9ABCDEF0, "R6 data kept");

        // R3 split write path, interrupt + error completion
        wr(6'h29, 64'h4C00012C);
        wr(6'h2a, 64'h000F0000);
        check("R3 inj_insn from 0x29", {32'h0, inj_insn}, 64'h4C00012C);
        check("R4 inj_thread 3", {62'h0, inj_thread}, 64'h3);
        check("R4 inj_ext 0", {60'h0, inj_ext}, 64'h0);
        pulse(0, 1, 1, 64'hAA);
        rd(6'h2a, 64'h000F0006, "R6 intr+err status");
        rd(6'h2d, 64'hAA, "R6 result AA");

        // R7 flush only
        wr(6'h2a, 64'h000C0800);
        check("R7 flush_req", {63'h0, flush_req}, 64'h1);
        check("R7 no inject", {63'h0, inj_valid}, 64'h0);
        check("R7 flush thread", {62'h0, inj_thread}, 64'h2);
        rd(6'h2a, 64'h000C0806, "R7 status unchanged");

        // R8 idle
        wr(6'h2a, 64'h0);
        check("R8 no flush", {63'h0, flush_req}, 64'h0);
        rd(6'h2a, 64'h00000006, "R8 idle keeps status");

        // R11 data write
        wr(6'h2d, 64'hDEADBEEF_00000001);
        rd(6'h2d, 64'hDEADBEEF_00000001, "R11 data write");

        // R5 injection enable cleared
        wr(6'h33, 64'h80000000);
        wr(6'h2a, 64'h00090000);
        check("R5 no inject inj disabled", {63'h0, inj_valid}, 64'h0);
        rd(6'h2a, 64'h00090002, "R5 error inj disabled");
        pulse(1, 0, 0, 64'h77);
        rd(6'h2d, 64'hDEADBEEF_00000001, "R6 pulse after refusal ignored");
        rd(6'h31, 64'h0, "R2 0x31 reads zero");

        repeat (3) @(negedge clk);
        fin = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule